// File: doc/BRIEF.md
# Global-History Paired One-Bit Branch Predictor

This block predicts whether a conditional branch will be taken. A table of entries, selected by a few low bits of the branch address, gives each entry two one-bit predictors: one consulted when the branch that resolved most recently went not-taken, the other when it went taken. A single global history bit holds that most recent outcome. The prediction for a branch therefore tracks how the preceding branch, of whatever address, went, and not only the branch's own past.

A fetch stage presents an address on the lookup port and reads the prediction in the same cycle. When a branch resolves, the execute stage presents its address and real outcome on the update port. The block then overwrites the predictor chosen by the current history bit, loads the outcome into the history bit, and counts a misprediction if the chosen predictor disagreed. No tag is kept, so branches whose index bits match share one entry, and that sharing can help or hurt accuracy.

Top module: `gsel_branch_pred`

## Requirements
- R1: After a synchronous active-high reset, every predictor in every entry holds not-taken (0), the history bit holds taken (1) and the miss counter reads 0, so a lookup at any address returns 0.
- R2: The entry is chosen by address bits [5:2] (16 entries by default). No tag is compared, so two addresses equal in bits [5:2] read and write the same entry.
- R3: The lookup output is combinational: it is the predictor of the addressed entry chosen by the history bit, the if-last-taken predictor when the bit is 1 and the if-last-not-taken predictor when it is 0.
- R4: A valid update overwrites only the predictor chosen by the history bit as it stood before the update, at the entry of the update address, with the outcome; the other predictor of that entry and all other entries keep their values.
- R5: After each valid update the history bit equals that update's outcome.
- R6: While the update valid input is 0, no predictor, the history bit and the counter change, whatever the other update inputs carry.
- R7: A lookup in the same cycle as an update sees the table and history bit as they were before that update; the update is seen from the next cycle on.
- R8: The 16-bit miss counter adds one for each valid update whose selected predictor differs from the outcome, and is unchanged on a correct update.
- R9: The miss counter saturates: once at 65535 it stays at 65535 on further mispredictions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_addr | input | 32 | Branch address to predict |
| lk_taken | output | 1 | Prediction, 1 = taken |
| upd_valid | input | 1 | A branch resolved this cycle |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| miss_count | output | 16 | Saturating misprediction count |

## Verification
Two branches at distinct entries with alternating outcomes show whether the history bit, rather than each branch's own past, picks the predictor. Pairs of addresses equal in bits [5:2] but differing above them separate indexing by the right bits from indexing by the wrong ones, and a same-address lookup during an update tells pre-update from post-update reads. Idle cycles with noisy update fields show the valid gate, a long run of random outcomes compares every prediction to an independent model, and a forced stream of over 65535 mispredictions exposes wrap-around versus saturation.

// File: rtl/gsel_branch_pred.sv
module gsel_branch_pred #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int IDX_LO  = 2,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_taken,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [ENTRIES-1:0] pred_nt, pred_t;
  logic               hist;
  logic [IDX_W-1:0]   lk_idx, up_idx;
  logic               up_pred, miss;

  assign lk_idx   = lk_addr[IDX_LO +: IDX_W];
  assign up_idx   = upd_addr[IDX_LO +: IDX_W];
  assign lk_taken = hist ? pred_t[lk_idx] : pred_nt[lk_idx];
  assign up_pred  = hist ? pred_t[up_idx] : pred_nt[up_idx];
  assign miss     = upd_valid && (up_pred != upd_taken);

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_nt    <= '0;
      pred_t     <= '0;
      hist       <= 1'b1;
      miss_count <= '0;
    end else if (upd_valid) begin
      if (hist) pred_t[up_idx]  <= upd_taken;
      else      pred_nt[up_idx] <= upd_taken;
      hist <= upd_taken;
      if (miss && miss_count != CNT_MAX) miss_count <= miss_count + 1'b1;
    end
  end

  // R5
  hist_follow_chk: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> hist == $past(upd_taken));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(hist) && $stable(miss_count) && $stable(pred_t) && $stable(pred_nt));

  // R4
  other_half_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && hist) |=> $stable(pred_nt));

  // R4
  other_half_nt_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !hist) |=> $stable(pred_t));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_count == CNT_MAX) |=> (miss_count == CNT_MAX));

  // R8
  hit_no_count_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !miss) |=> $stable(miss_count));

  // R8
  miss_count_chk: assert property (@(posedge clk) disable iff (rst)
    (miss && miss_count != CNT_MAX) |=> miss_count == $past(miss_count) + 1'b1);
endmodule

// File: tb/gsel_branch_pred_tb.sv
module gsel_branch_pred_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] lk_addr = 0;
  logic        lk_taken;
  logic        upd_valid = 0;
  logic [31:0] upd_addr = 0;
  logic        upd_taken = 0;
  logic [15:0] miss_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit    m_nt[16];
  bit    m_t[16];
  bit    m_h;
  int    m_cnt;

  bit    qp[$];
  int    qc[$];
  string qr[$];

  always #10 clk = ~clk;

  gsel_branch_pred u_dut (
    .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_taken(lk_taken),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken),
    .miss_count(miss_count)
  );

  function automatic bit model_pred(logic [31:0] a);
    return m_h ? m_t[a[5:2]] : m_nt[a[5:2]];
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 16; i++) begin m_nt[i] = 0; m_t[i] = 0; end
    m_h = 1; m_cnt = 0;
  endfunction

  task automatic step(input logic [31:0] la, input bit uv, input logic [31:0] ua,
                      input bit ut, input string req);
    @(negedge clk);
    lk_addr = la; upd_valid = uv; upd_addr = ua; upd_taken = ut;
    qp.push_back(model_pred(la));
    qc.push_back(m_cnt);
    qr.push_back(req);
    if (uv) begin
      if (model_pred(ua) != ut && m_cnt < 65535) m_cnt++;
      if (m_h) m_t[ua[5:2]] = ut; else m_nt[ua[5:2]] = ut;
      m_h = ut;
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #5;
      if (qp.size() > 0) begin
        bit p; int c; string r;
        p = qp.pop_front(); c = qc.pop_front(); r = qr.pop_front();
        checks++;
        if (lk_taken !== p) begin
          errors++;
          $display("FAIL %s lk_taken actual %0b expected %0b", r, lk_taken, p);
        end
        checks++;
        if (miss_count !== c[15:0]) begin
          errors++;
          $display("FAIL %s miss_count actual %0d expected %0d", r, miss_count, c);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state at several addresses
    for (int i = 0; i < 16; i++) step(32'h1000 + i * 4, 0, 0, 0, "R1");
    // R3 R5: two branches alternating outcomes at distinct entries
    for (int k = 0; k < 12; k++) begin
      step(32'h0000_0008, 1, 32'h0000_0004, k[0], "R3");
      step(32'h0000_0004, 1, 32'h0000_0008, ~k[1], "R5");
    end
    // R2 aliasing: 0x04 and 0x44 share entry 1, 0x84 too
    step(32'h0000_0044, 1, 32'h0000_0004, 1, "R2");
    step(32'h0000_0084, 1, 32'h0000_0044, 0, "R2");
    step(32'h0000_0004, 1, 32'h0000_0104, 1, "R2");
    step(32'h0000_0044, 0, 0, 0, "R2");
    // R7 lookup of the address being updated in the same cycle
    for (int k = 0; k < 8; k++) step(32'h0000_0030, 1, 32'h0000_0030, k[1] ^ k[0], "R7");
    step(32'h0000_0030, 0, 0, 0, "R7");
    // R6 idle cycles with noisy update fields
    for (int k = 0; k < 20; k++) step(32'h0 + k * 4, 0, 32'h0 + k * 4, k[0], "R6");
    // R4 R8 random stream
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      step(a, ($urandom % 4) != 0, b, $urandom % 2, "R4");
    end
    step(32'h0, 0, 0, 0, "R8");
    // R9 forced mispredictions beyond saturation
    for (int k = 0; k < 65600; k++) begin
      logic [31:0] a;
      a = 32'h0 + (k % 16) * 4;
      step(a, 1, a, ~model_pred(a), "R9");
    end
    step(32'h0, 0, 0, 0, "R9");
    // R1 reset clears state again
    @(negedge clk); rst = 1; upd_valid = 0;
    @(negedge clk); rst = 0;
    model_reset();
    for (int i = 0; i < 4; i++) step(32'h20 + i * 4, 0, 0, 0, "R1");
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule